// File: doc/BRIEF.md
# Video Line Chroma Decimation Formatter

This block takes a 4:2:2 pixel stream and repacks it into 32-bit words in a chosen chroma subsampling format. Each input beat carries one luma sample and one chroma sample. Chroma alternates Cb, Cr, Cb, Cr along the line, and the first pixel of every line carries Cb. Flags on the beat mark start of frame, start of line and the last pixel of a line. The stream is valid/ready on both sides. A single output register sits between the packer and the output port, so backpressure from the output stalls the input.

A 3-bit format code selects the output format. The choices are full 4:2:2, horizontally decimated 4:1:1, two vertically decimated formats (4:2:0 and 4:1:0), and luma only. The vertically decimated formats send chroma on only some lines of a field. The other lines carry luma only. A 2-bit lead count sets how many luma-only lines come before the first line that carries chroma. Format code and lead count are both captured on the start-of-frame beat. A line's bytes are packed in order into words, with the first byte in bits 7:0. The final word of each line is flagged, and its unused bytes are set to zero.

Top module: `vid_chroma_fmt`

## Requirements
- R1: Format code 000 (4:2:2): each pixel pair p, p+1 yields one word, {Y(p+1), Cr(p+1), Y(p), Cb(p)} from bit 31 down to bit 0.
- R2: Format code 001 (4:1:1): each group of four pixels yields six bytes in the order Cb(p0), Y(p0), Cr(p1), Y(p1), Y(p2), Y(p3). The chroma of p2 and p3 is dropped.
- R3: Format code 010 (4:2:0): once the lead lines have passed, every second line carries chroma and is packed as in R1. All other lines send luma bytes only.
- R4: Format code 011 (4:1:0): once the lead lines have passed, every fourth line carries chroma and is packed as in R2. All other lines send luma bytes only.
- R5: Format code 100 sends luma bytes only on every line.
- R6: Format codes 101, 110 and 111 produce no output words. No output is produced after reset until a start-of-frame beat has been accepted. After reset, out_valid_o is 0 and in_ready_o is 1.
- R7: In formats 010 and 011, the lead count L (0 to 3) makes lines 0 to L-1 of the frame luma only, and line L carries chroma. In all other formats the lead count has no effect.
- R8: Format code and lead count are taken only from the start-of-frame beat. Changes on later beats of the same frame have no effect.
- R9: The word that holds a line's last byte has out_last_o set. Byte lanes of that word that hold no data are zero.
- R10: While out_valid_o is 1 and out_ready_i is 0, the output word and its flag are held stable and in_ready_o is 0.
- R11: Line selection restarts at every start-of-frame beat, whatever phase the previous frame ended in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | Beat is the first pixel of a frame |
| in_sol_i | input | 1 | Beat is the first pixel of a line |
| in_eol_i | input | 1 | Beat is the last pixel of a line |
| in_y_i | input | SAMPLE_W | Luma sample |
| in_c_i | input | SAMPLE_W | Chroma sample (Cb on even pixels, Cr on odd) |
| fmt_sel_i | input | 3 | Output format code |
| lead_i | input | 2 | Luma-only lines before the first chroma line |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts output word |
| out_data_o | output | 4*SAMPLE_W | Packed output word |
| out_last_o | output | 1 | Word is the last of its line |

## Verification
The bench uses a 4:1:1 line of six pixels and a luma-only line of six pixels, so that the last word of each line is only partly filled. A design that mis-handled this would leave stale bytes in the unused lanes or drop the flush at the end of the line. The 4:2:0 and 4:1:0 runs use every lead count from 0 to 3, and one frame ends in the middle of a decimation phase just before a new frame begins. These runs expose line selection that is off by one, a lead count that is ignored, and a phase that carries over from the previous frame. Format and lead are changed in the middle of a frame to catch configuration that is sampled on every line. Random output stalls check that the held word never changes and that no input is taken while the output is blocked.

// File: rtl/vcdf_pkg.sv
package vcdf_pkg;
  localparam logic [2:0] FMT_422 = 3'b000;
  localparam logic [2:0] FMT_411 = 3'b001;
  localparam logic [2:0] FMT_420 = 3'b010;
  localparam logic [2:0] FMT_410 = 3'b011;
  localparam logic [2:0] FMT_Y   = 3'b100;

  typedef enum logic [1:0] {
    LM_NONE = 2'd0,
    LM_422  = 2'd1,
    LM_411  = 2'd2,
    LM_Y    = 2'd3
  } line_mode_e;
endpackage

// File: rtl/vcdf_line_sched.sv
module vcdf_line_sched
  import vcdf_pkg::*;
#(
  parameter int LEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic              line_start_i,
  input  logic              sof_i,
  input  logic [2:0]        fmt_i,
  input  logic [LEAD_W-1:0] lead_i,
  output line_mode_e        mode_o
);
  localparam int PH_W = 2;

  logic [2:0]        fmt_q, fmt_eff;
  logic [LEAD_W-1:0] lead_left_q, lead_eff, lead_nxt;
  logic [PH_W-1:0]   phase_q, phase_eff, phase_nxt;
  line_mode_e        mode_q, new_mode;
  logic              chroma_line;

  assign fmt_eff   = sof_i ? fmt_i  : fmt_q;
  assign lead_eff  = sof_i ? lead_i : lead_left_q;
  assign phase_eff = sof_i ? '0     : phase_q;

  always_comb begin
    new_mode    = LM_NONE;
    lead_nxt    = lead_eff;
    phase_nxt   = phase_eff;
    chroma_line = 1'b0;
    case (fmt_eff)
      FMT_422: new_mode = LM_422;
      FMT_411: new_mode = LM_411;
      FMT_420, FMT_410: begin
        if (lead_eff != '0) begin
          new_mode = LM_Y;
          lead_nxt = lead_eff - 1'b1;
        end else begin
          chroma_line = (fmt_eff == FMT_420) ? (phase_eff[0] == 1'b0) : (phase_eff == '0);
          if (chroma_line) new_mode = (fmt_eff == FMT_420) ? LM_422 : LM_411;
          else             new_mode = LM_Y;
          phase_nxt = phase_eff + 1'b1;
        end
      end
      FMT_Y:   new_mode = LM_Y;
      default: new_mode = LM_NONE;
    endcase
  end

  assign mode_o = line_start_i ? new_mode : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q       <= 3'b111;
      lead_left_q <= '0;
      phase_q     <= '0;
      mode_q      <= LM_NONE;
    end else if (beat_i) begin
      if (sof_i) fmt_q <= fmt_i;
      if (line_start_i) begin
        mode_q      <= new_mode;
        lead_left_q <= lead_nxt;
        phase_q     <= phase_nxt;
      end
    end
  end

  // R7
  lead_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && line_start_i && !sof_i |=> lead_left_q <= $past(lead_left_q));
endmodule

// File: rtl/vcdf_byte_sel.sv
module vcdf_byte_sel
  import vcdf_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                beat_i,
  input  logic                line_start_i,
  input  line_mode_e          mode_i,
  input  logic [SAMPLE_W-1:0] y_i,
  input  logic [SAMPLE_W-1:0] c_i,
  output logic [1:0]          n_o,
  output logic [SAMPLE_W-1:0] b0_o,
  output logic [SAMPLE_W-1:0] b1_o
);
  logic [1:0] idx_q, idx;

  assign idx = line_start_i ? 2'd0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= 2'd0;
    else if (beat_i) idx_q <= idx + 2'd1;
  end

  always_comb begin
    n_o  = 2'd0;
    b0_o = '0;
    b1_o = '0;
    case (mode_i)
      LM_422: begin
        n_o = 2'd2; b0_o = c_i; b1_o = y_i;
      end
      LM_411: begin
        // keep Cb of pixel 0 and Cr of pixel 1 in each group of four
        if (!idx[1]) begin
          n_o = 2'd2; b0_o = c_i; b1_o = y_i;
        end else begin
          n_o = 2'd1; b0_o = y_i;
        end
      end
      LM_Y: begin
        n_o = 2'd1; b0_o = y_i;
      end
      default: n_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/vcdf_packer.sv
module vcdf_packer #(
  parameter int SAMPLE_W = 8,
  parameter int BYTES    = 4,
  localparam int WORD_W  = BYTES * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                beat_i,
  input  logic                line_start_i,
  input  logic                eol_i,
  input  logic [1:0]          n_i,
  input  logic [SAMPLE_W-1:0] b0_i,
  input  logic [SAMPLE_W-1:0] b1_i,
  input  logic                out_ready_i,
  output logic                room_o,
  output logic                out_valid_o,
  output logic [WORD_W-1:0]   out_data_o,
  output logic                out_last_o
);
  logic [SAMPLE_W-1:0] acc_q [BYTES];
  logic [SAMPLE_W-1:0] slot  [BYTES];
  logic [1:0]          cnt_q;
  logic [2:0]          base, tot;
  logic                emit;

  always_comb begin
    base = line_start_i ? 3'd0 : {1'b0, cnt_q};
    tot  = base + {1'b0, n_i};
    for (int i = 0; i < BYTES; i++) begin
      if (3'(i) < base)                              slot[i] = acc_q[i];
      else if (n_i != 2'd0 && 3'(i) == base)         slot[i] = b0_i;
      else if (n_i == 2'd2 && 3'(i) == base + 3'd1)  slot[i] = b1_i;
      else                                           slot[i] = '0;
    end
  end

  assign emit   = beat_i && (tot == 3'(BYTES) || (eol_i && tot != 3'd0));
  assign room_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= 2'd0;
      for (int i = 0; i < BYTES; i++) acc_q[i] <= '0;
    end else if (beat_i) begin
      if (emit) begin
        cnt_q <= 2'd0;
        for (int i = 0; i < BYTES; i++) acc_q[i] <= '0;
      end else begin
        cnt_q <= tot[1:0];
        for (int i = 0; i < BYTES; i++) acc_q[i] <= slot[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_data_o  <= '0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_last_o  <= eol_i;
      for (int i = 0; i < BYTES; i++) out_data_o[i*SAMPLE_W +: SAMPLE_W] <= slot[i];
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R9
  fill_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> tot <= 3'(BYTES));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
endmodule

// File: rtl/vid_chroma_fmt.sv
module vid_chroma_fmt
  import vcdf_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LEAD_W   = 2,
  localparam int WORD_W  = 4 * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_sof_i,
  input  logic                in_sol_i,
  input  logic                in_eol_i,
  input  logic [SAMPLE_W-1:0] in_y_i,
  input  logic [SAMPLE_W-1:0] in_c_i,
  input  logic [2:0]          fmt_sel_i,
  input  logic [LEAD_W-1:0]   lead_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WORD_W-1:0]   out_data_o,
  output logic                out_last_o
);
  logic                beat, line_start, room;
  line_mode_e          mode;
  logic [1:0]          n_bytes;
  logic [SAMPLE_W-1:0] b0, b1;

  assign in_ready_o = room;
  assign beat       = in_valid_i && room;
  assign line_start = in_sol_i || in_sof_i;

  vcdf_line_sched #(.LEAD_W(LEAD_W)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (beat),
    .line_start_i (line_start),
    .sof_i        (in_sof_i),
    .fmt_i        (fmt_sel_i),
    .lead_i       (lead_i),
    .mode_o       (mode)
  );

  vcdf_byte_sel #(.SAMPLE_W(SAMPLE_W)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (beat),
    .line_start_i (line_start),
    .mode_i       (mode),
    .y_i          (in_y_i),
    .c_i          (in_c_i),
    .n_o          (n_bytes),
    .b0_o         (b0),
    .b1_o         (b1)
  );

  vcdf_packer #(.SAMPLE_W(SAMPLE_W), .BYTES(4)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (beat),
    .line_start_i (line_start),
    .eol_i        (in_eol_i),
    .n_i          (n_bytes),
    .b0_i         (b0),
    .b1_i         (b1),
    .out_ready_i  (out_ready_i),
    .room_o       (room),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o)
  );

  // R6
  out_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));
endmodule

// File: tb/vid_chroma_fmt_test.sv
module vid_chroma_fmt_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_sof_i = 1'b0, in_sol_i = 1'b0, in_eol_i = 1'b0;
  logic [7:0]  in_y_i = '0, in_c_i = '0;
  logic [2:0]  fmt_sel_i = '0;
  logic [1:0]  lead_i = '0;
  logic        in_ready_o, out_valid_o, out_last_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;

  always #2.5 clk = ~clk;

  vid_chroma_fmt uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_sof_i(in_sof_i), .in_sol_i(in_sol_i), .in_eol_i(in_eol_i),
    .in_y_i(in_y_i), .in_c_i(in_c_i), .fmt_sel_i(fmt_sel_i), .lead_i(lead_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] cap_d [256];
  logic        cap_l [256];
  int          cap_n = 0;
  logic [31:0] exp_d [256];
  logic        exp_l [256];
  int          exp_n = 0;
  logic        bp_en = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  logic        hold_seen = 1'b0;
  logic [31:0] hold_d;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  // random output stalls
  always @(negedge clk) begin
    #1;
    if (bp_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready_i = lfsr[0];
    end else begin
      out_ready_i = 1'b1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      if (hold_seen) begin
        chk("R10 held valid", 32'(out_valid_o), 32'd1);
        chk("R10 held data", out_data_o, hold_d);
      end
      hold_seen = 1'b0;
      if (out_valid_o && !out_ready_i) begin
        hold_seen = 1'b1;
        hold_d    = out_data_o;
        chk("R10 in_ready low while blocked", 32'(in_ready_o), 32'd0);
      end
      if (out_valid_o && out_ready_i && cap_n < 256) begin
        cap_d[cap_n] = out_data_o;
        cap_l[cap_n] = out_last_o;
        cap_n++;
      end
    end
  end

  function automatic logic [7:0] py(int fid, int k, int p);
    return 8'(fid * 61 + k * 13 + p * 3 + 7);
  endfunction

  function automatic logic [7:0] pc(int fid, int k, int p);
    return 8'(fid * 29 + k * 7 + p * 11 + 100);
  endfunction

  task automatic push(input logic sof, input logic sol, input logic eol,
                      input logic [7:0] y, input logic [7:0] c,
                      input logic [2:0] f, input logic [1:0] l);
    @(negedge clk);
    #1;
    in_valid_i = 1'b1; in_sof_i = sof; in_sol_i = sol; in_eol_i = eol;
    in_y_i = y; in_c_i = c; fmt_sel_i = f; lead_i = l;
    #1;
    while (!in_ready_o) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    in_valid_i = 1'b0; in_sof_i = 1'b0; in_sol_i = 1'b0; in_eol_i = 1'b0;
  endtask

  task automatic send_frame(input int fid, input logic [2:0] f, input logic [1:0] l,
                            input int nl, input int np, input logic [2:0] alt_f,
                            input logic [1:0] alt_l, input bit use_sof);
    for (int k = 0; k < nl; k++)
      for (int p = 0; p < np; p++) begin
        bit first;
        first = (k == 0 && p == 0);
        push(use_sof && first, p == 0, p == np - 1, py(fid, k, p), pc(fid, k, p),
             first ? f : alt_f, first ? l : alt_l);
      end
    idle();
  endtask

  // expected words built from the requirements
  task automatic expect_frame(input int fid, input int f, input int l, input int nl, input int np);
    for (int k = 0; k < nl; k++) begin
      int m;
      logic [7:0] b [64];
      int nb;
      case (f)
        0: m = 1;
        1: m = 2;
        2: m = (k >= l && (k - l) % 2 == 0) ? 1 : 3;
        3: m = (k >= l && (k - l) % 4 == 0) ? 2 : 3;
        4: m = 3;
        default: m = 0;
      endcase
      nb = 0;
      if (m != 0) begin
        for (int p = 0; p < np; p++) begin
          if (m == 1 || (m == 2 && p % 4 < 2)) begin
            b[nb] = pc(fid, k, p); nb++;
            b[nb] = py(fid, k, p); nb++;
          end else begin
            b[nb] = py(fid, k, p); nb++;
          end
        end
        for (int w = 0; w < nb; w += 4) begin
          logic [31:0] word;
          word = '0;
          for (int j = 0; j < 4; j++)
            if (w + j < nb) word[8*j +: 8] = b[w + j];
          exp_d[exp_n] = word;
          exp_l[exp_n] = (w + 4 >= nb);
          exp_n++;
        end
      end
    end
  endtask

  task automatic start_case();
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic compare(input string req, input int drain);
    repeat (drain) @(negedge clk);
    #3;
    chk({req, " word count"}, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < cap_n && i < exp_n; i++) begin
      chk({req, " data"}, cap_d[i], exp_d[i]);
      chk({req, " R9 last flag"}, 32'(cap_l[i]), 32'(exp_l[i]));
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R6 reset out_valid", 32'(out_valid_o), 32'd0);
    chk("R6 reset in_ready", 32'(in_ready_o), 32'd1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    start_case();
    send_frame(0, 3'b000, 2'd0, 2, 4, 3'b000, 2'd0, 1'b0);
    compare("R6 no frame yet", 10);
  endtask

  task automatic t_422();
    start_case();
    send_frame(1, 3'b000, 2'd3, 2, 8, 3'b000, 2'd3, 1'b1);
    expect_frame(1, 0, 3, 2, 8);
    compare("R1 R7 4:2:2", 10);
  endtask

  task automatic t_411();
    start_case();
    send_frame(2, 3'b001, 2'd2, 2, 6, 3'b001, 2'd2, 1'b1);
    expect_frame(2, 1, 2, 2, 6);
    compare("R2 R9 4:1:1 padded", 10);
  endtask

  task automatic t_420();
    start_case();
    send_frame(3, 3'b010, 2'd0, 4, 8, 3'b010, 2'd0, 1'b1);
    expect_frame(3, 2, 0, 4, 8);
    send_frame(4, 3'b010, 2'd1, 5, 4, 3'b010, 2'd1, 1'b1);
    expect_frame(4, 2, 1, 5, 4);
    compare("R3 R7 4:2:0", 10);
  endtask

  task automatic t_410();
    start_case();
    send_frame(5, 3'b011, 2'd3, 9, 8, 3'b011, 2'd3, 1'b1);
    expect_frame(5, 3, 3, 9, 8);
    send_frame(14, 3'b011, 2'd2, 3, 4, 3'b011, 2'd2, 1'b1);
    expect_frame(14, 3, 2, 3, 4);
    compare("R4 R7 4:1:0", 10);
  endtask

  task automatic t_yonly();
    start_case();
    send_frame(6, 3'b100, 2'd2, 3, 6, 3'b100, 2'd2, 1'b1);
    expect_frame(6, 4, 2, 3, 6);
    compare("R5 R9 luma only", 10);
  endtask

  task automatic t_undef();
    start_case();
    send_frame(7, 3'b101, 2'd0, 2, 4, 3'b101, 2'd0, 1'b1);
    send_frame(8, 3'b111, 2'd1, 2, 4, 3'b111, 2'd1, 1'b1);
    send_frame(15, 3'b110, 2'd0, 1, 4, 3'b110, 2'd0, 1'b1);
    compare("R6 undefined code", 10);
  endtask

  task automatic t_midchange();
    start_case();
    send_frame(9, 3'b000, 2'd0, 2, 4, 3'b100, 2'd3, 1'b1);
    expect_frame(9, 0, 0, 2, 4);
    send_frame(10, 3'b010, 2'd1, 4, 4, 3'b000, 2'd0, 1'b1);
    expect_frame(10, 2, 1, 4, 4);
    compare("R8 mid-frame change", 10);
  endtask

  task automatic t_restart();
    start_case();
    send_frame(11, 3'b010, 2'd0, 3, 4, 3'b010, 2'd0, 1'b1);
    expect_frame(11, 2, 0, 3, 4);
    send_frame(12, 3'b011, 2'd0, 2, 4, 3'b011, 2'd0, 1'b1);
    expect_frame(12, 3, 0, 2, 4);
    compare("R11 phase restart", 10);
  endtask

  task automatic t_backpressure();
    start_case();
    bp_en = 1'b1;
    send_frame(13, 3'b000, 2'd0, 3, 8, 3'b000, 2'd0, 1'b1);
    expect_frame(13, 0, 0, 3, 8);
    send_frame(16, 3'b001, 2'd0, 2, 10, 3'b001, 2'd0, 1'b1);
    expect_frame(16, 1, 0, 2, 10);
    repeat (40) @(negedge clk);
    bp_en = 1'b0;
    compare("R10 stalls", 10);
  endtask

  initial begin
    t_reset();
    t_422();
    t_411();
    t_420();
    t_410();
    t_yonly();
    t_undef();
    t_midchange();
    t_restart();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule